// File: doc/BRIEF.md
# Stipple and Blit Write Accelerator

This block sits between a register bus and a frame memory holding one 8-bit colour index per pixel. Software issues short commands that would otherwise take many separate pixel writes. A stipple command applies a 32-bit mask to a run of 32 consecutive pixels and paints the colour register wherever the mask has a one. A blit command either fills a run of 1 to 32 pixels with the colour register or copies a run of the same length from another pixel address.

Each pixel owns a slot of two 32-bit words in the command space. A write to the low word of any slot loads the shared colour register. A write to the high word starts a command whose destination is that slot's pixel. The destination pixel is therefore taken from the bus address, and the data word carries the mask, or the source address and run length. The block drives a single-port synchronous RAM (one read or one write per cycle, read data valid on the next cycle) and raises `busy` while a command runs. Bus writes that arrive while it is busy are dropped, and reads of the command space return zero.

Top module: `stv_blit_engine`

## Requirements
- R1: After reset `busy` is 0, the memory port is idle (`mem_we` = 0, `mem_re` = 0) and the colour register holds 0. Whenever `busy` is 0, the memory port stays idle.
- R2: `bus_addr` is a 32-bit word address. Bit 0 selects the word: 0 loads the colour register from `bus_wdata[COL_W-1:0]`, and 1 starts a command. Bits [PIX_W:1] give the destination pixel. Bit PIX_W+1 selects the command kind: 0 for stipple, 1 for blit. Colour loads behave the same in both regions and at every pixel slot.
- R3: A stipple command with destination D writes the colour to pixel D+k (k = 0..31) exactly when mask bit 31-k is 1, and leaves the other pixels unchanged. `busy` stays high for exactly 32 cycles, whatever the mask.
- R4: In a blit command, `bus_wdata[28:24]` holds the run length minus one, giving L = 1..32. When `bus_wdata[23:0]` is 24'hFFFFFF, pixels D..D+L-1 are filled with the colour, and `busy` stays high for exactly L cycles.
- R5: Any other value of `bus_wdata[23:0]` copies the run in ascending order: pixel D+k receives the current value of pixel S+k for k = 0, 1, 2, ... in turn. An overlapping forward copy therefore repeats the source pattern. `busy` stays high for exactly 2L cycles.
- R6: Destination and source pixel addresses wrap modulo 2^PIX_W. The source S is `bus_wdata[PIX_W-1:0]`, and the higher bits of the source field take part only in the fill test.
- R7: While `busy` is 1, every bus write, whether a colour load or a command, is ignored. It changes neither memory nor the colour register, and it starts nothing.
- R8: A bus read is answered one cycle later by `bus_rvalid` = 1 with `bus_rdata` = 0.
- R9: The memory port never reads and writes in the same cycle, and every copy write follows, in the next cycle, the read that supplies its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | PIX_W+2 | Word address: region, pixel, word select |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read data, always zero |
| busy | output | 1 | A command is running |
| mem_we | output | 1 | Frame memory write enable |
| mem_re | output | 1 | Frame memory read enable |
| mem_addr | output | PIX_W | Frame memory pixel address |
| mem_wdata | output | COL_W | Frame memory write data |
| mem_rdata | input | COL_W | Frame memory read data, one cycle after `mem_re` |

## Verification
The bench builds the block with PIX_W = 6, so the frame memory has 64 pixels. At that size every one of the 64 destination pixels can be hit by its own stipple command, and every fill length from 1 to 32 can be swept. Runs of up to 32 pixels cross the top of the address space often, so wrap-around of both source and destination is exercised routinely. Because the whole memory fits in a reference array in the bench, every pixel is compared after every command, which catches stray writes as well as missing ones.

// File: rtl/stv_pkg.sv
package stv_pkg;
   localparam int unsigned STIP_PIX  = 32;
   localparam int unsigned RUN_W     = 5;
   localparam int unsigned SRC_FLD_W = 24;
   localparam int unsigned LEN_LSB   = 24;
   localparam logic [SRC_FLD_W-1:0] FILL_KEY = '1;

   typedef enum logic [1:0] {
      OP_STIP = 2'd0,
      OP_FILL = 2'd1,
      OP_COPY = 2'd2
   } stv_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_STIP = 3'd1,
      ST_FILL = 3'd2,
      ST_CRD  = 3'd3,
      ST_CWR  = 3'd4
   } stv_state_e;
endpackage

// File: rtl/stv_cmd_decode.sv
module stv_cmd_decode
   import stv_pkg::*;
#(
   parameter int unsigned PIX_W = 20,
   parameter int unsigned COL_W = 8,
   localparam int unsigned ADDR_W = PIX_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 busy,
   output logic                 start,
   output stv_op_e              op,
   output logic [PIX_W-1:0]     dst,
   output logic [PIX_W-1:0]     src,
   output logic [RUN_W-1:0]     len_m1,
   output logic [STIP_PIX-1:0]  pattern,
   output logic [COL_W-1:0]     colour,
   output logic                 bus_rvalid,
   output logic [31:0]          bus_rdata
);
   logic             hi_word;
   logic             blit_rgn;
   logic             colour_ld;
   logic [COL_W-1:0] colour_q;
   logic             rvalid_q;

   assign hi_word  = bus_addr[0];
   assign blit_rgn = bus_addr[ADDR_W-1];
   assign colour_ld = bus_wr && !hi_word && !busy;
   assign start     = bus_wr && hi_word && !busy;

   assign dst     = bus_addr[PIX_W:1];
   assign src     = bus_wdata[PIX_W-1:0];
   assign len_m1  = bus_wdata[LEN_LSB +: RUN_W];
   assign pattern = bus_wdata;

   always_comb begin
      if (!blit_rgn)
         op = OP_STIP;
      else if (bus_wdata[SRC_FLD_W-1:0] == FILL_KEY)
         op = OP_FILL;
      else
         op = OP_COPY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         colour_q <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= bus_rd;
         if (colour_ld)
            colour_q <= bus_wdata[COL_W-1:0];
      end
   end

   assign colour     = colour_q;
   assign bus_rvalid = rvalid_q;
   assign bus_rdata  = '0;

   // R7: a write while the engine runs must leave the colour alone
   assert_busy_colour_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr) |=> $stable(colour_q));
endmodule

// File: rtl/stv_wrap_add.sv
module stv_wrap_add #(
   parameter int unsigned W     = 20,
   parameter int unsigned OFS_W = 5
) (
   input  logic [W-1:0]     base,
   input  logic [OFS_W-1:0] ofs,
   output logic [W-1:0]     sum
);
   generate
      if (W >= OFS_W) begin : g_wide
         assign sum = base + {{(W-OFS_W){1'b0}}, ofs};
      end else begin : g_narrow
         assign sum = base + ofs[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/stv_run_engine.sv
module stv_run_engine
   import stv_pkg::*;
#(
   parameter int unsigned PIX_W = 20,
   parameter int unsigned COL_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  stv_op_e              op,
   input  logic [PIX_W-1:0]     dst,
   input  logic [PIX_W-1:0]     src,
   input  logic [RUN_W-1:0]     len_m1,
   input  logic [STIP_PIX-1:0]  pattern,
   input  logic [COL_W-1:0]     colour,
   output logic                 busy,
   output logic                 mem_we,
   output logic                 mem_re,
   output logic [PIX_W-1:0]     mem_addr,
   output logic [COL_W-1:0]     mem_wdata,
   input  logic [COL_W-1:0]     mem_rdata
);
   localparam logic [RUN_W-1:0] STIP_LAST = RUN_W'(STIP_PIX - 1);

   stv_state_e          state_q;
   logic [PIX_W-1:0]    dst_q;
   logic [PIX_W-1:0]    src_q;
   logic [RUN_W-1:0]    last_q;
   logic [RUN_W-1:0]    idx_q;
   logic [STIP_PIX-1:0] pat_q;
   logic [PIX_W-1:0]    wr_addr;
   logic [PIX_W-1:0]    rd_addr;

   stv_wrap_add #(.W(PIX_W), .OFS_W(RUN_W)) u_wr_add (
      .base (dst_q),
      .ofs  (idx_q),
      .sum  (wr_addr)
   );

   stv_wrap_add #(.W(PIX_W), .OFS_W(RUN_W)) u_rd_add (
      .base (src_q),
      .ofs  (idx_q),
      .sum  (rd_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dst_q   <= '0;
         src_q   <= '0;
         last_q  <= '0;
         idx_q   <= '0;
         pat_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  dst_q <= dst;
                  src_q <= src;
                  pat_q <= pattern;
                  idx_q <= '0;
                  case (op)
                     OP_STIP: begin
                        last_q  <= STIP_LAST;
                        state_q <= ST_STIP;
                     end
                     OP_FILL: begin
                        last_q  <= len_m1;
                        state_q <= ST_FILL;
                     end
                     default: begin
                        last_q  <= len_m1;
                        state_q <= ST_CRD;
                     end
                  endcase
               end
            end
            ST_STIP, ST_FILL: begin
               pat_q <= {pat_q[STIP_PIX-2:0], 1'b0};
               idx_q <= idx_q + 1'b1;
               if (idx_q == last_q)
                  state_q <= ST_IDLE;
            end
            ST_CRD: begin
               state_q <= ST_CWR;
            end
            ST_CWR: begin
               if (idx_q == last_q) begin
                  state_q <= ST_IDLE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_CRD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy      = (state_q != ST_IDLE);
      mem_re    = (state_q == ST_CRD);
      mem_we    = ((state_q == ST_STIP) && pat_q[STIP_PIX-1]) ||
                  (state_q == ST_FILL) || (state_q == ST_CWR);
      mem_addr  = (state_q == ST_CRD) ? rd_addr : wr_addr;
      mem_wdata = (state_q == ST_CWR) ? mem_rdata : colour;
   end

   // R9: the single port never reads and writes together
   assert_no_rw_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R9: a copy write always follows the read that fed it
   assert_copy_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CWR) |-> $past(mem_re));

   // R1: no memory traffic while idle
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));

   // R6: consecutive fill writes step by one pixel, wrapping at the top
   assert_fill_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_FILL) && $past(state_q == ST_FILL)) |->
         (mem_addr == PIX_W'($past(mem_addr) + 1'b1)));
endmodule

// File: rtl/stv_blit_engine.sv
module stv_blit_engine
   import stv_pkg::*;
#(
   parameter int unsigned PIX_W = 20,
   parameter int unsigned COL_W = 8,
   localparam int unsigned ADDR_W = PIX_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_rvalid,
   output logic [31:0]       bus_rdata,
   output logic              busy,
   output logic              mem_we,
   output logic              mem_re,
   output logic [PIX_W-1:0]  mem_addr,
   output logic [COL_W-1:0]  mem_wdata,
   input  logic [COL_W-1:0]  mem_rdata
);
   generate
      if (PIX_W < 1 || PIX_W > SRC_FLD_W) begin : g_bad_pix
         $error("stv_blit_engine: PIX_W must lie in 1..24");
      end
      if (COL_W < 1 || COL_W > 32) begin : g_bad_col
         $error("stv_blit_engine: COL_W must lie in 1..32");
      end
   endgenerate

   logic                start;
   stv_op_e             op;
   logic [PIX_W-1:0]    dst;
   logic [PIX_W-1:0]    src;
   logic [RUN_W-1:0]    len_m1;
   logic [STIP_PIX-1:0] pattern;
   logic [COL_W-1:0]    colour;

   stv_cmd_decode #(.PIX_W(PIX_W), .COL_W(COL_W)) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .busy       (busy),
      .start      (start),
      .op         (op),
      .dst        (dst),
      .src        (src),
      .len_m1     (len_m1),
      .pattern    (pattern),
      .colour     (colour),
      .bus_rvalid (bus_rvalid),
      .bus_rdata  (bus_rdata)
   );

   stv_run_engine #(.PIX_W(PIX_W), .COL_W(COL_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .op        (op),
      .dst       (dst),
      .src       (src),
      .len_m1    (len_m1),
      .pattern   (pattern),
      .colour    (colour),
      .busy      (busy),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );
endmodule

// File: tb/stv_blit_engine_tb_top.sv
`timescale 1ns/1ps
module stv_blit_engine_tb_top;
   localparam int PW = 6;
   localparam int NPIX = 1 << PW;
   localparam int AW = PW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_rvalid;
   logic [31:0]   bus_rdata;
   logic          busy;
   logic          mem_we;
   logic          mem_re;
   logic [PW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;

   logic [7:0] fmem [NPIX];
   logic [7:0] model [NPIX];

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_we) fmem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= fmem[mem_addr];
   end

   stv_blit_engine #(.PIX_W(PW), .COL_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
      .bus_rdata(bus_rdata), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input bit blit, input int pix, input bit hi, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = {blit, PW'(pix), hi};
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic check_mem(input string req);
      int bad_i = -1;
      for (int i = 0; i < NPIX; i++)
         if (bad_i < 0 && fmem[i] !== model[i]) bad_i = i;
      if (bad_i < 0) chk(1'b1, req, "memory", 0, 0);
      else chk(1'b0, req, $sformatf("pixel %0d", bad_i), fmem[bad_i], model[bad_i]);
   endtask

   task automatic do_stip(input int d, input logic [31:0] pat, input logic [7:0] col);
      int n;
      wr(1'b0, (d * 13) % NPIX, 1'b0, {24'h0, col});
      wr(1'b0, d, 1'b1, pat);
      wait_idle(n);
      for (int k = 0; k < 32; k++)
         if (pat[31-k]) model[(d + k) % NPIX] = col;
      chk(n == 32, "R3", "stipple busy cycles", n, 32);
      check_mem("R3");
   endtask

   task automatic do_blit(input int d, input logic [31:0] fld, input logic [7:0] col,
                          input string req);
      int n;
      int len = int'(fld[28:24]) + 1;
      bit fill = (fld[23:0] == 24'hFFFFFF);
      int s = int'(fld[PW-1:0]);
      wr(1'b1, (d + 3) % NPIX, 1'b0, {24'h0, col});
      wr(1'b1, d, 1'b1, fld);
      wait_idle(n);
      for (int k = 0; k < len; k++)
         model[(d + k) % NPIX] = fill ? col : model[(s + k) % NPIX];
      chk(n == (fill ? len : 2 * len), req, "blit busy cycles", n, fill ? len : 2 * len);
      check_mem(req);
   endtask

   initial begin
      wait (cyc == 150000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int n;
      for (int i = 0; i < NPIX; i++) begin
         fmem[i] = 8'(i * 5 + 3);
         model[i] = 8'(i * 5 + 3);
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
      chk(mem_we == 1'b0 && mem_re == 1'b0, "R1", "memory port after reset",
          {mem_we, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0 && mem_we == 1'b0, "R1", "idle after release", {busy, mem_we}, 0);
      // R1: colour register resets to 0: a fill with no colour load writes 0
      wr(1'b1, 9, 1'b1, {3'b000, 5'd1, 24'hFFFFFF});
      wait_idle(n);
      model[9] = 8'h00;
      model[10] = 8'h00;
      check_mem("R1");

      // R8: reads answer with zero one cycle later
      @(negedge clk);
      bus_rd = 1'b1;
      bus_addr = {1'b1, 6'd20, 1'b1};
      @(negedge clk);
      bus_rd = 1'b0;
      chk(bus_rvalid == 1'b1, "R8", "read valid", bus_rvalid, 1);
      chk(bus_rdata == 32'h0, "R8", "read data", bus_rdata, 0);

      // R3 / R2: stipple at every destination pixel
      do_stip(0, 32'hFFFFFFFF, 8'hA1);
      do_stip(7, 32'h00000000, 8'hB2);
      do_stip(40, 32'h80000001, 8'hC3);
      for (int d = 0; d < NPIX; d++) begin
         logic [31:0] p = 32'h9E3779B9 ^ (32'(d) * 32'h01010101);
         do_stip(d, (p << (d % 32)) | (p >> (32 - d % 32)), 8'(d * 3 + 1));
      end

      // R4: fill every length
      for (int l = 1; l <= 32; l++)
         do_blit((l * 11) % NPIX, {3'b000, 5'(l - 1), 24'hFFFFFF}, 8'(l + 100), "R4");

      // R5: copy, including overlap in both directions
      do_blit(20, {3'b000, 5'd31, 24'd0}, 8'h11, "R5");
      do_blit(6, {3'b000, 5'd9, 24'd5}, 8'h12, "R5");
      do_blit(5, {3'b000, 5'd9, 24'd6}, 8'h13, "R5");
      do_blit(17, {3'b000, 5'd31, 24'd17}, 8'h14, "R5");
      // R6: wrapping source, wrapping destination, high source bits dropped
      do_blit(30, {3'b000, 5'd7, 24'd60}, 8'h15, "R6");
      do_blit(58, {3'b000, 5'd11, 24'd2}, 8'h16, "R6");
      do_blit(44, {3'b000, 5'd3, 24'h000041}, 8'h17, "R6");
      do_blit(12, {3'b000, 5'd4, 24'hFFFFFE}, 8'h18, "R6");

      // R7: writes during a run are ignored
      wr(1'b1, 0, 1'b0, 32'h5A);
      wr(1'b1, 10, 1'b1, {3'b000, 5'd31, 24'hFFFFFF});
      wr(1'b0, 3, 1'b0, 32'hC3);
      wr(1'b0, 50, 1'b1, 32'hFFFFFFFF);
      wait_idle(n);
      for (int k = 0; k < 32; k++) model[(10 + k) % NPIX] = 8'h5A;
      check_mem("R7");
      @(negedge clk);
      chk(busy == 1'b0, "R7", "ignored command started", busy, 0);
      wr(1'b1, 50, 1'b1, {3'b000, 5'd0, 24'hFFFFFF});
      wait_idle(n);
      model[50] = 8'h5A;
      check_mem("R7");

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule